// File: doc/BRIEF.md
# Reduced-Modulus State-Detect Counter

This block is a small binary up counter whose cycle length is cut below the natural 2^WIDTH states. The cut comes from a state detector on the registered count, and the detector drives the counter's clear. A parameter sets the cycle length K, from 2 up to one less than 2^WIDTH. A second parameter sets how the clear acts. In immediate style the detector looks for state K. That state is then treated as a short transient that stands in for zero. In synchronous style the detector looks for state K-1, and the counter wraps to zero on the next enabled clock edge.

The detector is a wide AND. Its inputs are only the count bits that are ones in the binary code of the detected value. Its output is active high, to match the active-high clear it feeds. When the counter runs freely it acts as a divide-by-K circuit. The divided output is the highest count bit that the K-state cycle actually toggles, so its period is K clock cycles. The order of states inside a period does not matter for this use. A terminal output marks the detected state. In immediate style a transient flag marks the state K.

Top module: `reduced_mod_counter`

## Requirements
- R1: While `rst` is high, the next clock edge sets `count` to 0. After reset, `term`, `transient` and `div_out` read 0.
- R2: With `en` low, `count` holds its value. The one exception is the immediate-style transient state K.
- R3: In synchronous style, enabled edges step `count` through 0, 1, ..., K-1. The enabled edge taken while in K-1 returns it to 0.
- R4: In immediate style, enabled edges step `count` upward until it reaches K. State K lasts exactly one cycle. The next edge gives 1 if `en` is high and 0 if it is low, as if the clear acted first and the count then applied.
- R5: `term` equals the AND of the count bits that are 1 in the detected value. For K=13 that means bits 0, 2 and 3 (value 13) in immediate style, and bits 2 and 3 (value 12) in synchronous style.
- R6: `term` is high exactly when `count` equals the detected value: K in immediate style, K-1 in synchronous style.
- R7: `transient` is high only in immediate style, and only while `count` equals K. In synchronous style it stays 0.
- R8: `div_out` is count bit floor(log2(K-1)), which is bit 3 for K=13. With `en` held high, successive rising edges of `div_out` are exactly K cycles apart.
- R9: `count` never exceeds the detected value: K in immediate style, K-1 in synchronous style.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Count enable |
| count | output | WIDTH | Registered count value |
| term | output | 1 | Detector output, high in the detected state |
| div_out | output | 1 | Divide-by-K output |
| transient | output | 1 | Marks the immediate-style state K |

## Verification
The assertions assume that `en` and `rst` are clean synchronous levels. They also assume the count has been reset at least once, because partial AND decoding relies on never starting from a state above the detected value. The bench changes inputs only on falling clock edges. It pulses reset at random from time to time, and it starts every run with a reset. Enable is random with a bias toward counting, so both the transient state and the wrap state are met with enable high and with enable low.

// File: rtl/rmc_pkg.sv
package rmc_pkg;

    typedef enum logic {
        CLR_IMMEDIATE = 1'b0,
        CLR_SYNC      = 1'b1
    } clr_style_e;

    typedef struct packed {
        logic term;
        logic transient;
        logic div;
    } rmc_flags_t;

    // Value the detector must recognise for a given modulus and clear style
    function automatic int detect_value(input int k, input clr_style_e style);
        return (style == CLR_SYNC) ? (k - 1) : k;
    endfunction

    // Highest bit set in k-1: the top count bit the K-state cycle toggles
    function automatic int top_bit(input int k);
        int b;
        b = 0;
        for (int i = 0; i < 31; i++) begin
            if (((k - 1) >> i) != 0) b = i;
        end
        return b;
    endfunction

endpackage

// File: rtl/rmc_detect.sv
module rmc_detect #(
    parameter int WIDTH = 4,
    parameter int MATCH = 13
) (
    input  logic [WIDTH-1:0] state,
    output logic             hit
);
    localparam logic [WIDTH-1:0] MASK = WIDTH'(MATCH);

    logic [WIDTH-1:0] tap;

    // Only bits that are ones in the match value take part in the AND
    for (genvar i = 0; i < WIDTH; i++) begin : g_tap
        if (MASK[i]) begin : g_use
            assign tap[i] = state[i];
        end else begin : g_skip
            assign tap[i] = 1'b1;
        end
    end

    assign hit = &tap;   // active high, matching the active-high clear
endmodule

// File: rtl/rmc_core.sv
module rmc_core #(
    parameter int                 WIDTH = 4,
    parameter rmc_pkg::clr_style_e STYLE = rmc_pkg::CLR_IMMEDIATE
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             clr,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] q_next;

    if (STYLE == rmc_pkg::CLR_IMMEDIATE) begin : g_imm
        // Clear acts at once; the pending count is applied to the cleared value
        always_comb begin
            if (clr) q_next = WIDTH'(en);
            else     q_next = q + WIDTH'(en);
        end
    end else begin : g_sync
        // Clear waits for the next enabled edge
        always_comb begin
            if (!en)      q_next = q;
            else if (clr) q_next = '0;
            else          q_next = q + WIDTH'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= q_next;
    end
endmodule

// File: rtl/reduced_mod_counter.sv
module reduced_mod_counter #(
    parameter int                  WIDTH     = 4,
    parameter int                  MODULUS   = 13,
    parameter rmc_pkg::clr_style_e CLR_STYLE = rmc_pkg::CLR_IMMEDIATE
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    output logic [WIDTH-1:0] count,
    output logic             term,
    output logic             div_out,
    output logic             transient
);
    import rmc_pkg::*;

    localparam int               DET     = detect_value(MODULUS, CLR_STYLE);
    localparam int               DIV_BIT = top_bit(MODULUS);
    localparam logic [WIDTH-1:0] DET_V   = WIDTH'(DET);
    localparam bit               IS_IMM  = (CLR_STYLE == CLR_IMMEDIATE);

    if (MODULUS < 2 || MODULUS >= (1 << WIDTH)) begin : g_bad_modulus
        $error("reduced_mod_counter: MODULUS out of range");
    end

    logic       hit;
    rmc_flags_t flags;

    rmc_core #(.WIDTH(WIDTH), .STYLE(CLR_STYLE)) u_core (
        .clk (clk),
        .rst (rst),
        .en  (en),
        .clr (hit),
        .q   (count)
    );

    rmc_detect #(.WIDTH(WIDTH), .MATCH(DET)) u_detect (
        .state (count),
        .hit   (hit)
    );

    always_comb begin
        flags.term      = hit;
        flags.transient = IS_IMM ? hit : 1'b0;
        flags.div       = count[DIV_BIT];
    end

    assign term      = flags.term;
    assign transient = flags.transient;
    assign div_out   = flags.div;

    // R9
    count_range_chk: assert property (@(posedge clk) disable iff (rst)
        count <= DET_V);

    // R6
    term_state_chk: assert property (@(posedge clk) disable iff (rst)
        term |-> (count == DET_V));

    if (IS_IMM) begin : g_chk_imm
        // R4
        transient_exit_chk: assert property (@(posedge clk) disable iff (rst)
            (count == DET_V) |=> (count == WIDTH'($past(en))));
        // R2
        hold_imm_chk: assert property (@(posedge clk) disable iff (rst)
            (!en && count != DET_V) |=> $stable(count));
        // R7
        transient_flag_chk: assert property (@(posedge clk) disable iff (rst)
            transient |-> (count == WIDTH'(MODULUS)));
    end else begin : g_chk_sync
        // R3
        sync_wrap_chk: assert property (@(posedge clk) disable iff (rst)
            (en && count == DET_V) |=> (count == '0));
        // R2
        hold_sync_chk: assert property (@(posedge clk) disable iff (rst)
            !en |=> $stable(count));
        // R7
        no_transient_chk: assert property (@(posedge clk) disable iff (rst)
            !transient);
    end
endmodule

// File: tb/test_reduced_mod_counter.sv
module test_reduced_mod_counter;
    import rmc_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 4;
    localparam int K          = 13;
    localparam int DIVB       = 3;      // floor(log2(12))

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         en  = 1'b0;
    logic [W-1:0] cnt_i, cnt_s;
    logic         term_i, term_s, div_i, div_s, tr_i, tr_s;

    int checks = 0;
    int fails  = 0;
    int qi, qs;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    reduced_mod_counter #(.WIDTH(W), .MODULUS(K), .CLR_STYLE(CLR_IMMEDIATE)) i_reduced_mod_counter (
        .clk(clk), .rst(rst), .en(en),
        .count(cnt_i), .term(term_i), .div_out(div_i), .transient(tr_i));

    reduced_mod_counter #(.WIDTH(W), .MODULUS(K), .CLR_STYLE(CLR_SYNC)) i_reduced_mod_counter_sync (
        .clk(clk), .rst(rst), .en(en),
        .count(cnt_s), .term(term_s), .div_out(div_s), .transient(tr_s));

    function automatic int nxt_imm(int q, bit e, bit r);
        if (r)      return 0;
        if (q == K) return e ? 1 : 0;
        return q + (e ? 1 : 0);
    endfunction

    function automatic int nxt_sync(int q, bit e, bit r);
        if (r)  return 0;
        if (!e) return q;
        return (q == K - 1) ? 0 : q + 1;
    endfunction

    function automatic bit and_of_mask(int c, int m);
        return (c & m) == m;
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic check_all(string tag_i, string tag_s);
        chk(tag_i, "imm count", int'(cnt_i), qi);
        chk(tag_s, "sync count", int'(cnt_s), qs);
        chk("R6", "imm term", int'(term_i), int'(qi == K));
        chk("R6", "sync term", int'(term_s), int'(qs == K - 1));
        chk("R5", "imm detector AND", int'(term_i), int'(and_of_mask(int'(cnt_i), 13)));
        chk("R5", "sync detector AND", int'(term_s), int'(and_of_mask(int'(cnt_s), 12)));
        chk("R7", "imm transient", int'(tr_i), int'(qi == K));
        chk("R7", "sync transient", int'(tr_s), 0);
        chk("R8", "imm div bit", int'(div_i), (qi >> DIVB) & 1);
        chk("R8", "sync div bit", int'(div_s), (qs >> DIVB) & 1);
        chk("R9", "imm range", int'(int'(cnt_i) <= K), 1);
        chk("R9", "sync range", int'(int'(cnt_s) <= K - 1), 1);
    endtask

    // Drive at a falling edge, advance the model, check at the next falling edge
    task automatic cycle(bit e, bit r);
        string ti, ts;
        ti = r ? "R1" : ((qi == K) ? "R4" : (e ? "R4" : "R2"));
        ts = r ? "R1" : (e ? "R3" : "R2");
        en  = e;
        rst = r;
        qi = nxt_imm(qi, e, r);
        qs = nxt_sync(qs, e, r);
        @(negedge clk);
        check_all(ti, ts);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete, actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        int last_rise_i, last_rise_s, t;
        bit pdi, pds;
        void'($urandom(32'd20240917));

        // R1: reset state
        rst = 1'b1; en = 1'b0;
        @(negedge clk);
        qi = 0; qs = 0;
        check_all("R1", "R1");
        chk("R1", "imm term after reset", int'(term_i), 0);
        chk("R1", "sync div after reset", int'(div_s), 0);

        // Directed: free-running count, period of the divided output (R8)
        last_rise_i = -1; last_rise_s = -1;
        pdi = div_i; pds = div_s;
        for (int n = 0; n < 60; n++) begin
            cycle(1'b1, 1'b0);
            t = n;
            if (div_i && !pdi) begin
                if (last_rise_i >= 0) chk("R8", "imm div period", t - last_rise_i, K);
                last_rise_i = t;
            end
            if (div_s && !pds) begin
                if (last_rise_s >= 0) chk("R8", "sync div period", t - last_rise_s, K);
                last_rise_s = t;
            end
            pdi = div_i; pds = div_s;
        end

        // Directed: stop in the transient / wrap state with enable low (R4, R2)
        while (qi != K) cycle(1'b1, 1'b0);
        cycle(1'b0, 1'b0);
        chk("R4", "imm transient exit with en low", int'(cnt_i), 0);
        cycle(1'b0, 1'b0);
        while (qs != K - 1) cycle(1'b1, 1'b0);
        cycle(1'b0, 1'b0);
        chk("R2", "sync held at K-1", int'(cnt_s), K - 1);
        cycle(1'b1, 1'b0);
        chk("R3", "sync wrap to zero", int'(cnt_s), 0);

        // Constrained random enable and occasional reset
        for (int n = 0; n < 4000; n++) begin
            cycle(($urandom % 4) != 0, ($urandom % 200) == 0);
        end

        done = 1'b1;
        summary();
        $finish;
    end
endmodule